// File: doc/BRIEF.md
# Buffer-to-Buffer Word Copy Engine

This block copies 32-bit words between two on-chip buffers: a line-interface data buffer with a 14-bit word address, and a USB endpoint buffer with a 10-bit word address. Firmware uses a small register file to set it up. It writes the first word offset for each buffer, then writes a control word that holds a direction bit and an encoded length. That control write starts the copy.

While a copy runs, the engine walks a source pointer and a destination pointer in step. It reads one word from the source buffer and writes that word to the destination buffer one cycle later. After the first word it keeps up one word per clock. Firmware polls a status word for the busy flag and the count of words still to go.

Each buffer is reached through a plain synchronous memory port: address, write enable, write data, and read data that is valid one cycle after the address.

Top module: `bufcopy_dma`

## Requirements
- R1: A bus write to byte address 0x00 while idle starts a copy. Control bit 14 picks the direction: 0 copies line buffer to USB buffer, 1 copies USB buffer to line buffer.
- R2: Control bits 11:0 hold the word count minus two. A copy moves exactly that value plus two words.
- R3: A bus read of address 0x00 returns the status word one cycle after the read request: bit 15 busy, bit 14 direction of the latest copy, bits 12:0 remaining count, all other bits zero.
- R4: At a start, the remaining count loads the word count minus one. It drops by one per destination write. When idle, including after reset, it reads 0x1FFF. Busy clears in the cycle the last destination write is presented.
- R5: Bits 13:0 of a write to address 0x08 give the line buffer word address used for the first word. Later words use addresses one higher each, wrapping modulo 16384.
- R6: Bits 9:0 of a write to address 0x0C give the USB buffer word address used for the first word. Later words use addresses one higher each, wrapping modulo 1024.
- R7: A copy does not change the offset registers. A following copy without new offset writes starts at the same two addresses.
- R8: A control write while busy is ignored. The running copy keeps its direction, length and addresses.
- R9: The first destination write is presented three cycles after the clock edge that accepts the start. The remaining writes follow in consecutive cycles.
- R10: Only the destination buffer is written, and at most one buffer per cycle. Word k written is the word read from source address offset+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data (status at 0x00, else zero) |
| ln_addr | output | 14 | Line buffer word address |
| ln_we | output | 1 | Line buffer write enable |
| ln_wdata | output | 32 | Line buffer write data |
| ln_rdata | input | 32 | Line buffer read data, one cycle after address |
| ub_addr | output | 10 | USB buffer word address |
| ub_we | output | 1 | USB buffer write enable |
| ub_wdata | output | 32 | USB buffer write data |
| ub_rdata | input | 32 | USB buffer read data, one cycle after address |

## Verification
The copy function is exercised with several kinds of transfer:
- The shortest transfer (length code 0, two words), which separates an off-by-one in the count encoding from a correct load.
- A full-length transfer, with offsets placed so that both pointers wrap past the end of their buffer.
- Random lengths, offsets and directions, which catch swapped ports and stuck pointers.
- Back-to-back copies without new offset writes, which show that the offset registers keep their values.
- A control write in the middle of a busy copy, which must leave the result unchanged.

For every transfer the bench compares these against values it computes itself:
- each destination address and data word;
- the cycle of each write;
- the status word right after the start and again after completion.

// File: rtl/bufcopy_pkg.sv
package bufcopy_pkg;
  localparam logic [3:0] REG_CTRL  = 4'h0;
  localparam logic [3:0] REG_LNOFF = 4'h8;
  localparam logic [3:0] REG_UBOFF = 4'hC;
  localparam int BUSY_BIT = 15;
  localparam int DIR_BIT  = 14;

  // Build the status word from busy, direction and a 13-bit remaining count.
  function automatic logic [31:0] pack_status(input logic busy, input logic dir,
                                              input logic [12:0] rem);
    logic [31:0] s;
    s = '0;
    s[BUSY_BIT] = busy;
    s[DIR_BIT]  = dir;
    s[12:0]     = rem;
    return s;
  endfunction
endpackage

// File: rtl/bufcopy_regs.sv
module bufcopy_regs
  import bufcopy_pkg::*;
#(
  parameter int LN_AW = 14,
  parameter int UB_AW = 10,
  parameter int LEN_W = 12,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  input  logic             dir,
  input  logic [CNT_W-1:0] rem,
  output logic             start,
  output logic             start_dir,
  output logic [LEN_W-1:0] start_len,
  output logic [LN_AW-1:0] ln_off,
  output logic [UB_AW-1:0] ub_off
);
  // A start is accepted only while idle.
  assign start     = bus_we && (bus_addr == REG_CTRL) && !busy;
  assign start_dir = bus_wdata[DIR_BIT];
  assign start_len = bus_wdata[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ln_off    <= '0;
      ub_off    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && bus_addr == REG_LNOFF) ln_off <= bus_wdata[LN_AW-1:0];
      if (bus_we && bus_addr == REG_UBOFF) ub_off <= bus_wdata[UB_AW-1:0];
      bus_rdata <= (bus_re && bus_addr == REG_CTRL) ?
                   pack_status(busy, dir, 13'(rem)) : '0;
    end
  end
endmodule

// File: rtl/bufcopy_port.sv
module bufcopy_port #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] off,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata
);
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      addr  <= '0;
      we    <= 1'b0;
      wdata <= '0;
    end else begin
      we <= wr_en;
      if (load) ptr <= off;
      else if (rd_en || wr_en) ptr <= ptr + 1'b1;
      if (rd_en || wr_en) addr <= ptr;
      if (wr_en) wdata <= din;
    end
  end

  // R9 / R5 / R6: writes in consecutive cycles go to consecutive addresses.
  a_r9_contiguous: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we)) |-> (addr == AW'($past(addr) + 1'b1)));
endmodule

// File: rtl/bufcopy_dma.sv
module bufcopy_dma #(
  parameter int LN_AW = 14,
  parameter int UB_AW = 10,
  parameter int DW    = 32,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [LN_AW-1:0] ln_addr,
  output logic             ln_we,
  output logic [DW-1:0]    ln_wdata,
  input  logic [DW-1:0]    ln_rdata,
  output logic [UB_AW-1:0] ub_addr,
  output logic             ub_we,
  output logic [DW-1:0]    ub_wdata,
  input  logic [DW-1:0]    ub_rdata
);
  localparam int CNT_W = LEN_W + 1;

  logic             start, start_dir;
  logic [LEN_W-1:0] start_len;
  logic [LN_AW-1:0] ln_off;
  logic [UB_AW-1:0] ub_off;
  logic             busy_q, dir_q, iss_q, dat_q;
  logic [CNT_W-1:0] rem_q, rd_left;
  logic             rd_go, wr_go;

  bufcopy_regs #(.LN_AW(LN_AW), .UB_AW(UB_AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_q), .dir(dir_q),
    .rem(rem_q), .start(start), .start_dir(start_dir), .start_len(start_len),
    .ln_off(ln_off), .ub_off(ub_off));

  assign rd_go = busy_q && (rd_left != '0);
  assign wr_go = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      rem_q   <= '1;
      rd_left <= '0;
      iss_q   <= 1'b0;
      dat_q   <= 1'b0;
    end else begin
      iss_q <= rd_go;
      dat_q <= iss_q;
      if (start) begin
        busy_q  <= 1'b1;
        dir_q   <= start_dir;
        rem_q   <= CNT_W'(start_len) + 1'b1;
        rd_left <= CNT_W'(start_len) + CNT_W'(2);
      end else begin
        if (rd_go) rd_left <= rd_left - 1'b1;
        if (wr_go) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == '0) busy_q <= 1'b0;
        end
      end
    end
  end

  bufcopy_port #(.AW(LN_AW), .DW(DW)) u_ln_port (
    .clk(clk), .rst(rst), .load(start), .off(ln_off),
    .rd_en(rd_go && !dir_q), .wr_en(wr_go && dir_q), .din(ub_rdata),
    .addr(ln_addr), .we(ln_we), .wdata(ln_wdata));

  bufcopy_port #(.AW(UB_AW), .DW(DW)) u_ub_port (
    .clk(clk), .rst(rst), .load(start), .off(ub_off),
    .rd_en(rd_go && dir_q), .wr_en(wr_go && !dir_q), .din(ln_rdata),
    .addr(ub_addr), .we(ub_we), .wdata(ub_wdata));

  // R4: the idle count always reads all ones.
  a_r4_idle_all_ones: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (rem_q == '1));
  // R10: never both buffers written in the same cycle.
  a_r10_single_writer: assert property (@(posedge clk) disable iff (rst)
    !(ln_we && ub_we));
  // R8: the direction holds for the whole copy.
  a_r8_dir_held: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(dir_q));
  // R10: the write goes to the buffer that the direction names.
  a_r10_dest_side: assert property (@(posedge clk) disable iff (rst)
    (ln_we || ub_we) |-> (ln_we == dir_q));
endmodule

// File: tb/bufcopy_dma_bench.sv
module bufcopy_dma_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [13:0] ln_addr;
  logic        ln_we;
  logic [31:0] ln_wdata, ln_rdata;
  logic [9:0]  ub_addr;
  logic        ub_we;
  logic [31:0] ub_wdata, ub_rdata;

  int total = 0, bad = 0, cyc = 0;
  int ncap = 0;
  int cap_addr [0:4199];
  logic [31:0] cap_data [0:4199];
  int cap_cyc  [0:4199];
  bit cap_ln   [0:4199];
  int cur_lo = 0, cur_uo = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bufcopy_dma u_bufcopy_dma (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ln_addr(ln_addr), .ln_we(ln_we),
    .ln_wdata(ln_wdata), .ln_rdata(ln_rdata), .ub_addr(ub_addr), .ub_we(ub_we),
    .ub_wdata(ub_wdata), .ub_rdata(ub_rdata));

  function automatic logic [31:0] lpat(int a);
    return 32'h1000_0000 ^ (32'(a) * 32'h9E37_79B1);
  endfunction
  function automatic logic [31:0] upat(int a);
    return 32'h2000_0000 ^ (32'(a) * 32'h85EB_CA6B);
  endfunction

  // Source memory models: one cycle of read latency.
  always @(posedge clk) begin
    ln_rdata <= lpat(int'(ln_addr));
    ub_rdata <= upat(int'(ub_addr));
  end

  // Capture every write presented on either port.
  always @(negedge clk) begin
    if (!rst && ncap < 4200) begin
      if (ln_we) begin
        cap_addr[ncap] = int'(ln_addr); cap_data[ncap] = ln_wdata;
        cap_cyc[ncap] = cyc; cap_ln[ncap] = 1'b1; ncap++;
      end
      if (ub_we) begin
        cap_addr[ncap] = int'(ub_addr); cap_data[ncap] = ub_wdata;
        cap_cyc[ncap] = cyc; cap_ln[ncap] = 1'b0; ncap++;
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(output logic [31:0] d);
    bus_re = 1'b1; bus_addr = 4'h0;
    @(negedge clk);
    d = bus_rdata; bus_re = 1'b0;
  endtask

  task automatic run_xfer(bit dir, int len, bit set_off, int lo, int uo, bit poke);
    int n, mark, bad_i;
    logic [31:0] st, expd;
    int expa;
    bit okc;
    n = len + 2;
    if (set_off) begin
      bus_write(4'h8, 32'(lo)); bus_write(4'hC, 32'(uo));
      cur_lo = lo & 16'h3FFF; cur_uo = uo & 10'h3FF;
    end
    ncap = 0;
    mark = cyc;
    bus_write(4'h0, (32'(dir) << 14) | 32'(len & 12'hFFF));
    bus_read(st);
    // R3 R4: status right after start
    check(st == {16'h0, 1'b1, dir, 1'b0, 13'(n - 1)}, "R3", "status after start", st,
          {16'h0, 1'b1, dir, 1'b0, 13'(n - 1)});
    // R8: the control write while busy carries the other direction and a short length.
    if (poke) bus_write(4'h0, ((32'(!dir)) << 14) | 32'd3);
    do bus_read(st); while (st[15]);
    // R2: exact word count
    check(ncap == n, "R2", "word count", 32'(ncap), 32'(n));
    // R5/R6/R10: address, side and data of every write
    okc = 1'b1; bad_i = 0;
    for (int k = 0; k < ncap && k < n; k++) begin
      expa = dir ? ((cur_lo + k) % 16384) : ((cur_uo + k) % 1024);
      expd = dir ? upat((cur_uo + k) % 1024) : lpat((cur_lo + k) % 16384);
      if (okc && (cap_ln[k] != dir || cap_addr[k] != expa || cap_data[k] != expd)) begin
        okc = 1'b0; bad_i = k;
      end
    end
    if (!okc) begin
      expa = dir ? ((cur_lo + bad_i) % 16384) : ((cur_uo + bad_i) % 1024);
      expd = dir ? upat((cur_uo + bad_i) % 1024) : lpat((cur_lo + bad_i) % 16384);
      check(1'b0, dir ? "R5" : "R6", "dest address", 32'(cap_addr[bad_i]), 32'(expa));
      check(1'b0, "R10", "dest data", cap_data[bad_i], expd);
    end else begin
      check(1'b1, "R5", "addr", 0, 0);
      check(1'b1, "R10", "data", 0, 0);
    end
    // R1: direction picks the destination
    check(ncap > 0 && cap_ln[0] == dir, "R1", "destination side", 32'(ncap > 0 ? cap_ln[0] : 0), 32'(dir));
    // R9: first write three cycles after the accepting edge, then one per cycle
    if (ncap > 0) begin
      check(cap_cyc[0] == mark + 4 + (set_off ? 2 : 0) - (set_off ? 2 : 0), "R9", "first write cycle",
            32'(cap_cyc[0] - mark), 32'd4);
      check(cap_cyc[ncap-1] - cap_cyc[0] == ncap - 1, "R9", "write span",
            32'(cap_cyc[ncap-1] - cap_cyc[0]), 32'(ncap - 1));
    end
    // R4: final status
    check(st == {16'h0, 1'b0, dir, 1'b0, 13'h1FFF}, "R4", "status when done", st,
          {16'h0, 1'b0, dir, 1'b0, 13'h1FFF});
  endtask

  initial begin
    logic [31:0] st;
    int rl;
    rl = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    bus_read(st);
    check(st == 32'h0000_1FFF, "R4", "status after reset", st, 32'h0000_1FFF);
    // R2 shortest copy, both directions
    run_xfer(1'b0, 0, 1'b1, 100, 200, 1'b0);
    run_xfer(1'b1, 0, 1'b1, 7, 9, 1'b0);
    // R7: same offsets reused without rewriting
    run_xfer(1'b0, 5, 1'b0, 0, 0, 1'b0);
    // R8: control write during busy ignored
    run_xfer(1'b1, 18, 1'b1, 300, 40, 1'b1);
    run_xfer(1'b0, 30, 1'b1, 1000, 500, 1'b1);
    // R5 R6: wrap of both pointers, full length
    run_xfer(1'b1, 12'hFFF, 1'b1, 16380, 1000, 1'b0);
    run_xfer(1'b0, 40, 1'b1, 16370, 1020, 1'b0);
    // Random mix
    for (int i = 0; i < 20; i++) begin
      run_xfer(1'($urandom), int'($urandom % 64), 1'b1,
               int'($urandom % 16384), int'($urandom % 1024), 1'($urandom % 4 == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule